// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the serial test port of a chip. An external tester drives a test clock, a mode-select line and a serial data input. It steps a sixteen-state sequencer on each rising test-clock edge. Through that sequencer the tester loads a five-bit instruction and then moves data through the register that the instruction selects. Two data registers live inside the block: a one-bit pass-through stage and a 32-bit identity word. The boundary-scan chain, a vendor command register and a separate debug port sit outside the block. Each of these has its own select line. The block also gives them capture, shift and update strobes, and their serial output comes back in on a single return input.

The block has no reset pin and takes no device reset. Its state changes only with the mode-select line. Holding that line high for five rising edges returns the port to its reset state from any state. Serial data goes out on falling edges. It comes with a separate drive-enable that the pad uses to float the pin outside the two shift states.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The sequencer moves between the sixteen standard test-port states on each rising edge of `tck_i`, following `tms_i`. `test_reset_o`, `capture_dr_o`, `shift_dr_o` and `update_dr_o` are each high exactly while the sequencer is in the reset, capture-data, shift-data or update-data state.
- R2: Five consecutive rising edges with `tms_i` high reach the reset state from any state. From shift-data, four such edges do not reach it.
- R3: The capture-instruction state loads the pattern 5'b00001 into the instruction shifter. That pattern appears first on `tdo_o` in shift-instruction, least significant bit first.
- R4: The instruction shifts in least significant bit first from `tdi_i` and takes effect only at the edge that leaves update-instruction. At most one of `sel_bsr_o`, `highz_o`, `sel_vendor_o` and `sel_dbg_o` is high.
- R5: `tdo_oe_o` rises on the first falling edge in shift-instruction or shift-data, and falls on the first falling edge after leaving that state. `tdo_o` changes only on falling edges.
- R6: The reset state loads opcode 0x01, which selects the identity register. The identity word has the revision in [31:28], the part number in [27:12], the manufacturer code 0x029 in [11:1] and a 1 in [0]. In shift-data it leaves least significant bit first over 32 falling edges.
- R7: Opcode 0x1F, and every opcode not listed in R6 and R8 to R10, selects the one-bit pass-through stage. That stage captures 0 and delays `tdi_i` by one bit.
- R8: Opcode 0x02 raises `sel_bsr_o` with `extest_o` low. Opcode 0x06 raises both. While either is active, shift-data returns `ext_tdo_i` on `tdo_o`.
- R9: Opcode 0x00 raises `highz_o` and puts the pass-through stage in the data path.
- R10: Opcode 0x07 raises `sel_vendor_o` and opcode 0x05 raises `sel_dbg_o`. Both return `ext_tdo_i` in shift-data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in, sampled on rising edge |
| ext_tdo_i | input | 1 | Serial return from the selected external data register |
| tdo_o | output | 1 | Serial data out, updated on falling edge |
| tdo_oe_o | output | 1 | Pad drive enable for tdo_o |
| test_reset_o | output | 1 | Sequencer is in the reset state |
| capture_dr_o | output | 1 | Capture strobe for external data registers |
| shift_dr_o | output | 1 | Shift strobe for external data registers |
| update_dr_o | output | 1 | Update strobe for external data registers |
| sel_bsr_o | output | 1 | Boundary-scan chain selected |
| extest_o | output | 1 | Boundary cells drive the pins |
| highz_o | output | 1 | All pins forced to input |
| sel_vendor_o | output | 1 | Vendor command register selected |
| sel_dbg_o | output | 1 | Debug port selected |

## Verification
The state strobes and the select lines follow one rising edge after the inputs are applied. `tdo_o` and `tdo_oe_o` follow at the falling edge after that rising edge. Each bench step therefore drives `tms_i`, `tdi_i` and `ext_tdo_i` just after a falling edge and passes one rising edge and one falling edge. It samples every output one time unit after that falling edge, so both results are settled when they are compared. A bench model advances under the same step rule and supplies the expected state, instruction and shift contents. It also supplies the expected output bit for each step. Directed scans collect the output bit from each step and compare the whole scanned word.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int unsigned IrW = 5;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IrW-1:0] OP_HIGHZ   = 5'h00;
  localparam logic [IrW-1:0] OP_IDCODE  = 5'h01;
  localparam logic [IrW-1:0] OP_SAMPLE  = 5'h02;
  localparam logic [IrW-1:0] OP_DBG     = 5'h05;
  localparam logic [IrW-1:0] OP_EXTEST  = 5'h06;
  localparam logic [IrW-1:0] OP_VENDOR  = 5'h07;
  localparam logic [IrW-1:0] OP_BYPASS  = 5'h1F;
  localparam logic [IrW-1:0] IR_CAPTURE = 5'b00001;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_TLR:      state_d = tms_i ? ST_TLR      : ST_RTI;
      ST_RTI:      state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   state_d = tms_i ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: state_d = tms_i ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms_i ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: state_d = tms_i ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   state_d = tms_i ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: state_d = tms_i ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms_i ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: state_d = tms_i ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      default:     state_d = ST_TLR;
    endcase
  end

  // no reset on purpose: only the mode-select sequence may move the port
  always_ff @(posedge tck_i) state_q <= state_d;

  assign state_o = state_q;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int unsigned       W         = IrW,
  parameter logic [W-1:0]      CAPT_VAL  = IR_CAPTURE,
  parameter logic [W-1:0]      RESET_OP  = OP_IDCODE
) (
  input  logic         tck_i,
  input  logic         tdi_i,
  input  tap_state_e   state_i,
  output logic [W-1:0] ir_o,
  output logic [W-1:0] ir_sh_o
);

  logic [W-1:0] ir_q, sh_q;

  always_ff @(posedge tck_i) begin
    unique case (state_i)
      ST_CAP_IR:   sh_q <= CAPT_VAL;
      ST_SHIFT_IR: sh_q <= {tdi_i, sh_q[W-1:1]};
      default:     sh_q <= sh_q;
    endcase
  end

  always_ff @(posedge tck_i) begin
    unique case (state_i)
      ST_TLR:    ir_q <= RESET_OP;
      ST_UPD_IR: ir_q <= sh_q;
      default:   ir_q <= ir_q;
    endcase
  end

  assign ir_o    = ir_q;
  assign ir_sh_o = sh_q;

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int unsigned     IdW    = 32,
  parameter logic [IdW-1:0]  ID_VAL = '1
) (
  input  logic       tck_i,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       byp_o,
  output logic       id_lsb_o
);

  logic           byp_q;
  logic [IdW-1:0] id_q;

  always_ff @(posedge tck_i) begin
    unique case (state_i)
      ST_CAP_DR: begin
        byp_q <= 1'b0;
        id_q  <= ID_VAL;
      end
      ST_SHIFT_DR: begin
        byp_q <= tdi_i;
        id_q  <= {tdi_i, id_q[IdW-1:1]};
      end
      default: begin
        byp_q <= byp_q;
        id_q  <= id_q;
      end
    endcase
  end

  assign byp_o    = byp_q;
  assign id_lsb_o = id_q[0];

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter logic [3:0]  ID_REV  = 4'h3,
  parameter logic [15:0] ID_PART = 16'h5A17,
  parameter logic [10:0] ID_MFR  = 11'h029
) (
  input  logic tck_i,
  input  logic tms_i,
  input  logic tdi_i,
  input  logic ext_tdo_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic test_reset_o,
  output logic capture_dr_o,
  output logic shift_dr_o,
  output logic update_dr_o,
  output logic sel_bsr_o,
  output logic extest_o,
  output logic highz_o,
  output logic sel_vendor_o,
  output logic sel_dbg_o
);

  localparam int unsigned IdW    = 4 + 16 + 11 + 1;
  localparam logic [IdW-1:0] ID_VAL = {ID_REV, ID_PART, ID_MFR, 1'b1};

  tap_state_e     state_q;
  logic [IrW-1:0] ir_q, ir_sh_q;
  logic           byp_q, id_lsb;
  logic           dr_id, dr_ext, dr_bit;
  logic           tdo_q, oe_q;

  jtag_tap_fsm i_fsm (
    .tck_i   (tck_i),
    .tms_i   (tms_i),
    .state_o (state_q)
  );

  jtag_tap_ir #(
    .W        (IrW),
    .CAPT_VAL (IR_CAPTURE),
    .RESET_OP (OP_IDCODE)
  ) i_ir (
    .tck_i   (tck_i),
    .tdi_i   (tdi_i),
    .state_i (state_q),
    .ir_o    (ir_q),
    .ir_sh_o (ir_sh_q)
  );

  jtag_tap_dr #(
    .IdW    (IdW),
    .ID_VAL (ID_VAL)
  ) i_dr (
    .tck_i    (tck_i),
    .tdi_i    (tdi_i),
    .state_i  (state_q),
    .byp_o    (byp_q),
    .id_lsb_o (id_lsb)
  );

  // opcode decode; anything unlisted falls to the pass-through stage
  always_comb begin
    sel_bsr_o    = 1'b0;
    extest_o     = 1'b0;
    highz_o      = 1'b0;
    sel_vendor_o = 1'b0;
    sel_dbg_o    = 1'b0;
    dr_id        = 1'b0;
    unique case (ir_q)
      OP_IDCODE: dr_id = 1'b1;
      OP_SAMPLE: sel_bsr_o = 1'b1;
      OP_EXTEST: begin
        sel_bsr_o = 1'b1;
        extest_o  = 1'b1;
      end
      OP_HIGHZ:  highz_o = 1'b1;
      OP_VENDOR: sel_vendor_o = 1'b1;
      OP_DBG:    sel_dbg_o = 1'b1;
      default: ;
    endcase
  end

  assign dr_ext = sel_bsr_o | sel_vendor_o | sel_dbg_o;
  assign dr_bit = dr_ext ? ext_tdo_i : (dr_id ? id_lsb : byp_q);

  always_ff @(negedge tck_i) begin
    if (state_q == ST_SHIFT_IR) begin
      tdo_q <= ir_sh_q[0];
      oe_q  <= 1'b1;
    end else if (state_q == ST_SHIFT_DR) begin
      tdo_q <= dr_bit;
      oe_q  <= 1'b1;
    end else begin
      tdo_q <= tdo_q;
      oe_q  <= 1'b0;
    end
  end

  assign tdo_o        = tdo_q;
  assign tdo_oe_o     = oe_q;
  assign test_reset_o = (state_q == ST_TLR);
  assign capture_dr_o = (state_q == ST_CAP_DR);
  assign shift_dr_o   = (state_q == ST_SHIFT_DR);
  assign update_dr_o  = (state_q == ST_UPD_DR);

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic           tck_i,
  input logic           tms_i,
  input logic           tdo_oe_o,
  input logic           test_reset_o,
  input logic           capture_dr_o,
  input logic           shift_dr_o,
  input logic           update_dr_o,
  input logic           sel_bsr_o,
  input logic           extest_o,
  input logic           highz_o,
  input logic           sel_vendor_o,
  input logic           sel_dbg_o,
  input tap_state_e     state_i,
  input logic [IrW-1:0] ir_i,
  input logic [IrW-1:0] ir_sh_i
);

  // port has no reset: checks arm once a full five-high sequence has been seen
  logic [2:0] hi_cnt = '0;
  logic       live   = 1'b0;

  always_ff @(posedge tck_i) begin
    hi_cnt <= tms_i ? ((hi_cnt == 3'd5) ? 3'd5 : hi_cnt + 3'd1) : 3'd0;
    live   <= live | (hi_cnt == 3'd5);
  end

  assert_strobe_excl_R1: assert property (@(posedge tck_i) disable iff (!live)
    $onehot0({test_reset_o, capture_dr_o, shift_dr_o, update_dr_o}));

  assert_capture_once_R1: assert property (@(posedge tck_i) disable iff (!live)
    capture_dr_o |=> !capture_dr_o);

  assert_tlr_after_five_R2: assert property (@(posedge tck_i) disable iff (!live)
    (hi_cnt == 3'd5) |-> test_reset_o);

  assert_ir_capture_R3: assert property (@(posedge tck_i) disable iff (!live)
    (state_i == ST_CAP_IR) |=> (ir_sh_i == IR_CAPTURE));

  assert_sel_onehot_R4: assert property (@(posedge tck_i) disable iff (!live)
    $onehot0({sel_bsr_o, highz_o, sel_vendor_o, sel_dbg_o}));

  assert_oe_window_R5: assert property (@(posedge tck_i) disable iff (!live)
    tdo_oe_o == ((state_i == ST_SHIFT_IR) || (state_i == ST_SHIFT_DR)));

  assert_tlr_idcode_R6: assert property (@(posedge tck_i) disable iff (!live)
    test_reset_o |=> (ir_i == OP_IDCODE));

  assert_extest_bsr_R8: assert property (@(posedge tck_i) disable iff (!live)
    extest_o |-> sel_bsr_o);

endmodule

bind jtag_tap_ctrl jtag_tap_chk i_chk (
  .tck_i        (tck_i),
  .tms_i        (tms_i),
  .tdo_oe_o     (tdo_oe_o),
  .test_reset_o (test_reset_o),
  .capture_dr_o (capture_dr_o),
  .shift_dr_o   (shift_dr_o),
  .update_dr_o  (update_dr_o),
  .sel_bsr_o    (sel_bsr_o),
  .extest_o     (extest_o),
  .highz_o      (highz_o),
  .sel_vendor_o (sel_vendor_o),
  .sel_dbg_o    (sel_dbg_o),
  .state_i      (state_q),
  .ir_i         (ir_q),
  .ir_sh_i      (ir_sh_q)
);

// File: tb/test_jtag_tap_ctrl.sv
module test_jtag_tap_ctrl;

  localparam int CLK_P = 10;
  localparam logic [31:0] EXP_ID = {4'h3, 16'h5A17, 11'h029, 1'b1};

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic tck = 1'b0;
  always #(CLK_P/2) tck = ~tck;

  logic tms_i = 1'b1, tdi_i = 1'b0, ext_tdo_i = 1'b0;
  logic tdo_o, tdo_oe_o, test_reset_o, capture_dr_o, shift_dr_o, update_dr_o;
  logic sel_bsr_o, extest_o, highz_o, sel_vendor_o, sel_dbg_o;

  jtag_tap_ctrl i_jtag_tap_ctrl (
    .tck_i(tck), .tms_i(tms_i), .tdi_i(tdi_i), .ext_tdo_i(ext_tdo_i),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o), .test_reset_o(test_reset_o),
    .capture_dr_o(capture_dr_o), .shift_dr_o(shift_dr_o), .update_dr_o(update_dr_o),
    .sel_bsr_o(sel_bsr_o), .extest_o(extest_o), .highz_o(highz_o),
    .sel_vendor_o(sel_vendor_o), .sel_dbg_o(sel_dbg_o)
  );

  int n_vec = 0, n_bad = 0;
  bit chk_en = 1'b0;
  logic ext_val = 1'b0;

  int          m_st = S_TLR;
  logic [4:0]  m_ir = 5'h01, m_irsh = '0;
  logic        m_byp = 1'b0, m_oe = 1'b0, m_tdo = 1'b0;
  logic [31:0] m_idsh = '0;

  logic       obs_tdo, obs_oe;
  logic [4:0] obs_sel;

  function automatic int nxt(input int s, input logic t);
    case (s)
      S_TLR:  return t ? S_TLR  : S_RTI;
      S_RTI:  return t ? S_SDR  : S_RTI;
      S_SDR:  return t ? S_SIR  : S_CDR;
      S_CDR:  return t ? S_E1DR : S_SHDR;
      S_SHDR: return t ? S_E1DR : S_SHDR;
      S_E1DR: return t ? S_UDR  : S_PDR;
      S_PDR:  return t ? S_E2DR : S_PDR;
      S_E2DR: return t ? S_UDR  : S_SHDR;
      S_UDR:  return t ? S_SDR  : S_RTI;
      S_SIR:  return t ? S_TLR  : S_CIR;
      S_CIR:  return t ? S_E1IR : S_SHIR;
      S_SHIR: return t ? S_E1IR : S_SHIR;
      S_E1IR: return t ? S_UIR  : S_PIR;
      S_PIR:  return t ? S_E2IR : S_PIR;
      S_E2IR: return t ? S_UIR  : S_SHIR;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  // {bsr, extest, highz, vendor, dbg}
  function automatic logic [4:0] exp_sel(input logic [4:0] ir);
    return {(ir == 5'h02) || (ir == 5'h06), ir == 5'h06, ir == 5'h00, ir == 5'h07, ir == 5'h05};
  endfunction

  function automatic bit ext_path(input logic [4:0] ir);
    return (ir == 5'h02) || (ir == 5'h06) || (ir == 5'h07) || (ir == 5'h05);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic tms, input logic tdi);
    string req;
    tms_i = tms; tdi_i = tdi; ext_tdo_i = ext_val;
    @(posedge tck);
    case (m_st)
      S_TLR:  m_ir = 5'h01;
      S_CIR:  m_irsh = 5'b00001;
      S_SHIR: m_irsh = {tdi, m_irsh[4:1]};
      S_UIR:  m_ir = m_irsh;
      S_CDR:  begin m_byp = 1'b0; m_idsh = EXP_ID; end
      S_SHDR: begin m_byp = tdi; m_idsh = {tdi, m_idsh[31:1]}; end
      default: ;
    endcase
    m_st = nxt(m_st, tms);
    @(negedge tck);
    if (m_st == S_SHIR) begin
      m_oe = 1'b1; m_tdo = m_irsh[0]; req = "R3";
    end else if (m_st == S_SHDR) begin
      m_oe = 1'b1;
      if (ext_path(m_ir))       begin m_tdo = ext_val;   req = "R8"; end
      else if (m_ir == 5'h01)   begin m_tdo = m_idsh[0]; req = "R6"; end
      else                      begin m_tdo = m_byp;     req = "R7"; end
    end else begin
      m_oe = 1'b0; req = "R5";
    end
    #1;
    obs_tdo = tdo_o;
    obs_oe  = tdo_oe_o;
    obs_sel = {sel_bsr_o, extest_o, highz_o, sel_vendor_o, sel_dbg_o};
    if (chk_en) begin
      chk({test_reset_o, capture_dr_o, shift_dr_o, update_dr_o} ==
          {m_st == S_TLR, m_st == S_CDR, m_st == S_SHDR, m_st == S_UDR}, "R1 strobes",
          {test_reset_o, capture_dr_o, shift_dr_o, update_dr_o},
          {m_st == S_TLR, m_st == S_CDR, m_st == S_SHDR, m_st == S_UDR});
      chk(obs_oe == m_oe, "R5 oe", obs_oe, m_oe);
      if (m_oe) chk(obs_tdo == m_tdo, req, obs_tdo, m_tdo);
      chk(obs_sel == exp_sel(m_ir), "R4 selects", obs_sel, exp_sel(m_ir));
    end
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap, output logic [4:0] sel_mid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = obs_tdo;
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      if (i < 4) cap[i+1] = obs_tdo;
    end
    sel_mid = obs_sel;
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = obs_tdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = obs_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [4:0]  cap, mid;
    logic [63:0] dout;
    void'($urandom(32'd1234));

    // R2: five highs synchronise from an unknown power-up state
    repeat (6) step(1, 0);
    m_st = S_TLR; m_ir = 5'h01; m_oe = 1'b0;
    chk_en = 1'b1;
    chk(test_reset_o == 1'b1, "R2 reset state", test_reset_o, 1);
    chk(tdo_oe_o == 1'b0, "R5 reset oe", tdo_oe_o, 0);
    chk(obs_sel == 5'b0, "R6 reset selects", obs_sel, 0);
    step(0, 0);

    // R6: identity word after reset, no instruction load
    shift_dr(32, 64'h0, dout);
    chk(dout[31:0] == EXP_ID, "R6 idcode", dout[31:0], EXP_ID);

    // R3 / R4: captured pattern, update only after update-instruction
    load_ir(5'h1F, cap, mid);
    chk(cap == 5'b00001, "R3 ir capture", cap, 5'b00001);
    chk(mid == 5'b0, "R4 select held before update", mid, 0);

    // R7: bypass and an unassigned opcode
    shift_dr(8, 64'hA5, dout);
    chk(dout[7:0] == 8'h4A, "R7 bypass 0x1F", dout[7:0], 8'h4A);
    load_ir(5'h13, cap, mid);
    shift_dr(8, 64'h3C, dout);
    chk(dout[7:0] == 8'h78, "R7 bypass unassigned", dout[7:0], 8'h78);

    // R8: boundary chain selects and external return
    load_ir(5'h06, cap, mid);
    chk(mid == 5'b0, "R4 extest not early", mid, 0);
    chk({sel_bsr_o, extest_o} == 2'b11, "R8 extest", {sel_bsr_o, extest_o}, 2'b11);
    ext_val = 1'b1;
    shift_dr(4, 64'h0, dout);
    chk(dout[3:0] == 4'hF, "R8 ext return 1", dout[3:0], 4'hF);
    ext_val = 1'b0;
    shift_dr(4, 64'hF, dout);
    chk(dout[3:0] == 4'h0, "R8 ext return 0", dout[3:0], 4'h0);
    load_ir(5'h02, cap, mid);
    chk({sel_bsr_o, extest_o} == 2'b10, "R8 sample", {sel_bsr_o, extest_o}, 2'b10);

    // R9: highz with pass-through path
    load_ir(5'h00, cap, mid);
    chk(highz_o == 1'b1, "R9 highz", highz_o, 1);
    shift_dr(3, 64'h5, dout);
    chk(dout[2:0] == 3'b010, "R9 bypass path", dout[2:0], 3'b010);

    // R10: vendor and debug selects
    load_ir(5'h07, cap, mid);
    chk(sel_vendor_o == 1'b1, "R10 vendor", sel_vendor_o, 1);
    ext_val = 1'b1;
    shift_dr(2, 64'h0, dout);
    chk(dout[1:0] == 2'b11, "R10 vendor return", dout[1:0], 2'b11);
    ext_val = 1'b0;
    load_ir(5'h05, cap, mid);
    chk(sel_dbg_o == 1'b1, "R10 debug", sel_dbg_o, 1);

    // R2 boundary: four highs from shift-data are not enough
    step(1, 0); step(0, 0); step(0, 0);
    repeat (4) step(1, 0);
    chk(test_reset_o == 1'b0, "R2 four highs", test_reset_o, 0);
    step(1, 0);
    chk(test_reset_o == 1'b1, "R2 fifth high", test_reset_o, 1);
    step(0, 0);

    // R5: enable window around shift-data
    step(1, 0); chk(obs_oe == 1'b0, "R5 select-dr", obs_oe, 0);
    step(0, 0); chk(obs_oe == 1'b0, "R5 capture-dr", obs_oe, 0);
    step(0, 0); chk(obs_oe == 1'b1, "R5 shift-dr", obs_oe, 1);
    step(1, 0); chk(obs_oe == 1'b0, "R5 exit-dr", obs_oe, 0);
    step(1, 0); step(0, 0);

    // random walk against the bench model (R1, R3..R10)
    for (int i = 0; i < 4000; i++) begin
      ext_val = 1'($urandom);
      step(1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule